// File: doc/BRIEF.md
# Two-Port Token Semaphore Bank

This block keeps a small set of binary tokens that two independent agents, a left side and a right side, use to agree on who may touch a shared resource. Either side picks one of the tokens with the low bits of its address, asks for it by writing a 0 on data bit 0 and gives it back by writing a 1. It then reads the token to learn whether it holds it: the holder reads 0 and everyone else reads 1. A request made while the other side holds the token is remembered. The token moves to the waiting side at the moment the holder gives it back, so the waiting side does not have to ask again.

Reads are captured on the first cycle of a read and held for as long as that read stays asserted. A side that is polling must therefore end its read and start a new one to see a change. The block is fully synchronous to one clock. It has a synchronous active-high reset that leaves every token free. Both sides use active-low strobes: a token-space select, a chip enable that must be high during token access, a write enable and an output enable.

Top module: `tok_semaphore_bank`

## Requirements
- R1: There are NFLAG (default 8) tokens. A side selects a token with address bits [2:0]. Address bits above bit 2 have no effect on which token is written or read.
- R2: A side makes a token access only when its select is low and its chip enable is high. With select and chip enable both low, or with select high, no token changes state and no read is captured.
- R3: During an access with write enable low, data bit 0 is the request bit: 0 requests the token and 1 releases it. Data bits 1 and up have no effect.
- R4: When a free token is requested by one side, that side reads 0 for it and the other side reads 1. A token that nobody holds reads 1 on both sides.
- R5: A request from the side that does not hold a token is stored as pending. It does not change who holds the token. Writes by the holder are the only writes that move the grant.
- R6: When the holder releases a token while the other side has a request pending, the other side holds it from the next cycle on. With nothing pending, the token becomes free.
- R7: When both sides request a free token in the same cycle, the left side gets it and the right request stays pending.
- R8: A read is an access with write enable high and output enable low. The token value is captured on the clock edge that ends the first cycle of the read. From the next cycle it is driven on all DW (default 18) read data bits, and it is held unchanged while the read stays asserted. When no read is held, read data is all zeros.
- R9: Reset is synchronous and active high. It makes every token free with no request pending, and it drives read data to zero on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lf_sel_n | input | 1 | Left token-space select, active low |
| lf_ce_n | input | 1 | Left chip enable, active low; must be high for token access |
| lf_we_n | input | 1 | Left write enable, active low |
| lf_oe_n | input | 1 | Left output enable, active low |
| lf_addr | input | AW (15) | Left address; bits [2:0] select the token |
| lf_wdata | input | DW (18) | Left write data; bit 0 is the request bit |
| lf_rdata | output | DW (18) | Left read data, captured token value replicated |
| rt_sel_n | input | 1 | Right token-space select, active low |
| rt_ce_n | input | 1 | Right chip enable, active low; must be high for token access |
| rt_we_n | input | 1 | Right write enable, active low |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_addr | input | AW (15) | Right address; bits [2:0] select the token |
| rt_wdata | input | DW (18) | Right write data; bit 0 is the request bit |
| rt_rdata | output | DW (18) | Right read data, captured token value replicated |

## Verification
The bench goes after the grant hand-off. A release by the holder while the other side waits must pass the token over, and a design that cleared the waiting request or needed a second request would leave the token free. Same-cycle requests from both sides must give the token to exactly the left side; a design without arbitration would let both sides read 0. A read held across the other side's hand-off must keep its captured value, where a design that forwarded live state would change mid-read. The bench also drives the forbidden select-plus-enable combination, noisy upper address and data bits, and writes by the side that does not hold the token. In each case a design that decoded too much would move a grant it should leave alone.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic en;
        logic val;
    } tok_wr_t;

    // Grant decision from the current holder and the request latches
    // as they will be after this cycle's writes (0 = requesting).
    function automatic owner_e next_owner(owner_e cur, logic nreq_l, logic nreq_r);
        owner_e nxt;
        nxt = cur;
        case (cur)
            OWN_LEFT:  if (nreq_l)  nxt = nreq_r ? OWN_NONE : OWN_RIGHT;
            OWN_RIGHT: if (nreq_r)  nxt = nreq_l ? OWN_NONE : OWN_LEFT;
            default: begin
                if (!nreq_l)      nxt = OWN_LEFT;
                else if (!nreq_r) nxt = OWN_RIGHT;
                else              nxt = OWN_NONE;
            end
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tsb_port.sv
module tsb_port
    import tsb_pkg::*;
#(
    parameter int NFLAG = 8,
    parameter int DW    = 18,
    parameter int AW    = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [NFLAG-1:0] view,
    output tok_wr_t          wr [NFLAG],
    output logic [DW-1:0]    rdata
);
    localparam int SELW = $clog2(NFLAG);

    logic            acc;
    logic            wr_act;
    logic            rd_act;
    logic [SELW-1:0] idx;
    logic            rd_held;
    logic            snap;

    // R2: token space only with select low and chip enable high
    assign acc    = !sel_n && ce_n;
    assign wr_act = acc && !we_n;
    assign rd_act = acc && we_n && !oe_n;
    // R1: only the low address bits pick the token
    assign idx    = addr[SELW-1:0];

    for (genvar g = 0; g < NFLAG; g++) begin : g_dec
        // R3: only data bit 0 carries the request
        assign wr[g].en  = wr_act && (idx == SELW'(g));
        assign wr[g].val = wdata[0];
    end

    // R8: capture on the first read cycle, hold while the read lasts
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_held <= 1'b0;
            snap    <= 1'b1;
        end else begin
            rd_held <= rd_act;
            if (rd_act && !rd_held)
                snap <= view[idx];
        end
    end

    assign rdata = rd_held ? {DW{snap}} : '0;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_act && rd_held) |=> $stable(rdata));

    // R2
    no_write_forbidden_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !ce_n) |-> !wr_act);

endmodule

// File: rtl/tsb_flag.sv
module tsb_flag
    import tsb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tok_wr_t lw,
    input  tok_wr_t rw,
    output logic    l_view,
    output logic    r_view
);
    logic   req_l, req_r;
    logic   nreq_l, nreq_r;
    owner_e owner;

    // R5: each side keeps its own request latch
    assign nreq_l = lw.en ? lw.val : req_l;
    assign nreq_r = rw.en ? rw.val : req_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_l <= 1'b1;
            req_r <= 1'b1;
            owner <= OWN_NONE;
        end else begin
            req_l <= nreq_l;
            req_r <= nreq_r;
            owner <= next_owner(owner, nreq_l, nreq_r);
        end
    end

    // R4: the holder reads 0, everyone else reads 1
    assign l_view = (owner != OWN_LEFT);
    assign r_view = (owner != OWN_RIGHT);

    // R6
    handoff_to_right_chk: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_LEFT && lw.en && lw.val && !rw.en && !req_r) |=> (owner == OWN_RIGHT));

    // R5
    holder_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_LEFT && !lw.en) |=> (owner == OWN_LEFT));

    // R7
    left_wins_tie_chk: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_NONE && lw.en && !lw.val && rw.en && !rw.val) |=> (!l_view && r_view));

    // R4
    single_holder_chk: assert property (@(posedge clk) disable iff (rst)
        !(!l_view && !r_view));

endmodule

// File: rtl/tok_semaphore_bank.sv
module tok_semaphore_bank
    import tsb_pkg::*;
#(
    parameter int NFLAG = 8,
    parameter int DW    = 18,
    parameter int AW    = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lf_sel_n,
    input  logic          lf_ce_n,
    input  logic          lf_we_n,
    input  logic          lf_oe_n,
    input  logic [AW-1:0] lf_addr,
    input  logic [DW-1:0] lf_wdata,
    output logic [DW-1:0] lf_rdata,
    input  logic          rt_sel_n,
    input  logic          rt_ce_n,
    input  logic          rt_we_n,
    input  logic          rt_oe_n,
    input  logic [AW-1:0] rt_addr,
    input  logic [DW-1:0] rt_wdata,
    output logic [DW-1:0] rt_rdata
);
    tok_wr_t          l_wr [NFLAG];
    tok_wr_t          r_wr [NFLAG];
    logic [NFLAG-1:0] l_view;
    logic [NFLAG-1:0] r_view;

    tsb_port #(.NFLAG(NFLAG), .DW(DW), .AW(AW)) u_lport (
        .clk(clk), .rst(rst),
        .sel_n(lf_sel_n), .ce_n(lf_ce_n), .we_n(lf_we_n), .oe_n(lf_oe_n),
        .addr(lf_addr), .wdata(lf_wdata), .view(l_view),
        .wr(l_wr), .rdata(lf_rdata)
    );

    tsb_port #(.NFLAG(NFLAG), .DW(DW), .AW(AW)) u_rport (
        .clk(clk), .rst(rst),
        .sel_n(rt_sel_n), .ce_n(rt_ce_n), .we_n(rt_we_n), .oe_n(rt_oe_n),
        .addr(rt_addr), .wdata(rt_wdata), .view(r_view),
        .wr(r_wr), .rdata(rt_rdata)
    );

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        tsb_flag u_flag (
            .clk(clk), .rst(rst),
            .lw(l_wr[g]), .rw(r_wr[g]),
            .l_view(l_view[g]), .r_view(r_view[g])
        );
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (lf_rdata == '0 && rt_rdata == '0));

endmodule

// File: tb/sim_tok_semaphore_bank.sv
module sim_tok_semaphore_bank;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 18;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lf_sel_n = 1'b1, lf_ce_n = 1'b1, lf_we_n = 1'b1, lf_oe_n = 1'b1;
    logic [AW-1:0] lf_addr = '0;
    logic [DW-1:0] lf_wdata = '0;
    logic [DW-1:0] lf_rdata;
    logic          rt_sel_n = 1'b1, rt_ce_n = 1'b1, rt_we_n = 1'b1, rt_oe_n = 1'b1;
    logic [AW-1:0] rt_addr = '0;
    logic [DW-1:0] rt_wdata = '0;
    logic [DW-1:0] rt_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tok_semaphore_bank #(.NFLAG(8), .DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst(rst),
        .lf_sel_n(lf_sel_n), .lf_ce_n(lf_ce_n), .lf_we_n(lf_we_n), .lf_oe_n(lf_oe_n),
        .lf_addr(lf_addr), .lf_wdata(lf_wdata), .lf_rdata(lf_rdata),
        .rt_sel_n(rt_sel_n), .rt_ce_n(rt_ce_n), .rt_we_n(rt_we_n), .rt_oe_n(rt_oe_n),
        .rt_addr(rt_addr), .rt_wdata(rt_wdata), .rt_rdata(rt_rdata)
    );

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rep(logic v);
        return {DW{v}};
    endfunction

    // side: 0 = left, 1 = right
    task automatic idle_side(bit side);
        if (!side) begin
            lf_sel_n = 1'b1; lf_ce_n = 1'b1; lf_we_n = 1'b1; lf_oe_n = 1'b1;
        end else begin
            rt_sel_n = 1'b1; rt_ce_n = 1'b1; rt_we_n = 1'b1; rt_oe_n = 1'b1;
        end
    endtask

    task automatic drive_wr(bit side, logic [AW-1:0] a, logic [DW-1:0] d);
        if (!side) begin
            lf_sel_n = 1'b0; lf_ce_n = 1'b1; lf_we_n = 1'b0; lf_oe_n = 1'b1;
            lf_addr = a; lf_wdata = d;
        end else begin
            rt_sel_n = 1'b0; rt_ce_n = 1'b1; rt_we_n = 1'b0; rt_oe_n = 1'b1;
            rt_addr = a; rt_wdata = d;
        end
    endtask

    task automatic drive_rd(bit side, logic [AW-1:0] a);
        if (!side) begin
            lf_sel_n = 1'b0; lf_ce_n = 1'b1; lf_we_n = 1'b1; lf_oe_n = 1'b0; lf_addr = a;
        end else begin
            rt_sel_n = 1'b0; rt_ce_n = 1'b1; rt_we_n = 1'b1; rt_oe_n = 1'b0; rt_addr = a;
        end
    endtask

    task automatic tok_write(bit side, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        drive_wr(side, a, d);
        @(negedge clk);
        idle_side(side);
    endtask

    task automatic tok_read_chk(bit side, logic [AW-1:0] a, logic exp, string req);
        @(negedge clk);
        drive_rd(side, a);
        @(negedge clk);
        chk(req, side ? rt_rdata : lf_rdata, rep(exp));
        idle_side(side);
    endtask

    task automatic both_read_chk(logic [AW-1:0] a, logic exp_l, logic exp_r, string req);
        tok_read_chk(1'b0, a, exp_l, req);
        tok_read_chk(1'b1, a, exp_r, req);
    endtask

    task automatic test_reset;
        chk("R9 left rdata after reset", lf_rdata, '0);
        chk("R9 right rdata after reset", rt_rdata, '0);
        for (int i = 0; i < 8; i++)
            both_read_chk(AW'(i), 1'b1, 1'b1, "R9 all tokens free after reset");
    endtask

    task automatic test_claim_pass;
        tok_write(1'b0, 15'd3, 18'h00000);
        both_read_chk(15'd3, 1'b0, 1'b1, "R4 left claims free token 3");
        both_read_chk(15'd4, 1'b1, 1'b1, "R1 neighbour token 4 untouched");
        tok_write(1'b1, 15'd3, 18'h00000);
        both_read_chk(15'd3, 1'b0, 1'b1, "R5 right request pends, left keeps token");
        tok_write(1'b0, 15'd3, 18'h00001);
        both_read_chk(15'd3, 1'b1, 1'b0, "R6 release passes token to waiting right");
        tok_write(1'b0, 15'd3, 18'h00000);
        both_read_chk(15'd3, 1'b1, 1'b0, "R5 left request while right holds");
        tok_write(1'b1, 15'd3, 18'h00001);
        both_read_chk(15'd3, 1'b0, 1'b1, "R6 token returns to waiting left");
        tok_write(1'b0, 15'd3, 18'h00001);
        both_read_chk(15'd3, 1'b1, 1'b1, "R6 release with nothing pending frees token");
    endtask

    task automatic test_tie;
        @(negedge clk);
        drive_wr(1'b0, 15'd5, 18'h00000);
        drive_wr(1'b1, 15'd5, 18'h00000);
        @(negedge clk);
        idle_side(1'b0);
        idle_side(1'b1);
        both_read_chk(15'd5, 1'b0, 1'b1, "R7 same-cycle request: left wins");
        tok_write(1'b0, 15'd5, 18'h00001);
        both_read_chk(15'd5, 1'b1, 1'b0, "R7 right request stayed pending");
        tok_write(1'b1, 15'd5, 18'h00001);
        both_read_chk(15'd5, 1'b1, 1'b1, "R7 token free again");
    endtask

    task automatic test_forbidden;
        @(negedge clk);
        lf_sel_n = 1'b0; lf_ce_n = 1'b0; lf_we_n = 1'b0; lf_oe_n = 1'b1;
        lf_addr = 15'd6; lf_wdata = 18'h00000;
        @(negedge clk);
        idle_side(1'b0);
        both_read_chk(15'd6, 1'b1, 1'b1, "R2 select with chip enable low changes nothing");
        @(negedge clk);
        rt_sel_n = 1'b0; rt_ce_n = 1'b0; rt_we_n = 1'b1; rt_oe_n = 1'b0; rt_addr = 15'd6;
        @(negedge clk);
        chk("R2 no read captured with chip enable low", rt_rdata, '0);
        idle_side(1'b1);
        @(negedge clk);
        rt_sel_n = 1'b1; rt_ce_n = 1'b1; rt_we_n = 1'b0; rt_addr = 15'd6; rt_wdata = '0;
        @(negedge clk);
        idle_side(1'b1);
        both_read_chk(15'd6, 1'b1, 1'b1, "R2 write with select high changes nothing");
    endtask

    task automatic test_addr_data_bits;
        tok_write(1'b1, 15'h7FF9, 18'h3FFFE);
        both_read_chk(15'h0001, 1'b1, 1'b0, "R1 R3 upper address and data bits ignored on claim");
        tok_write(1'b1, 15'h4C01, 18'h00001);
        both_read_chk(15'h2221, 1'b1, 1'b1, "R1 R3 release through aliased address");
        tok_write(1'b0, 15'd7, 18'h3FFFF);
        both_read_chk(15'd7, 1'b1, 1'b1, "R3 only bit 0 counts: all ones is a release");
    endtask

    task automatic test_snapshot;
        tok_write(1'b0, 15'd2, 18'h00000);
        tok_write(1'b1, 15'd2, 18'h00000);
        @(negedge clk);
        drive_rd(1'b1, 15'd2);
        @(negedge clk);
        chk("R8 right read captures 1 while left holds", rt_rdata, rep(1'b1));
        drive_wr(1'b0, 15'd2, 18'h00001);
        @(negedge clk);
        idle_side(1'b0);
        chk("R8 held read unchanged during hand-off", rt_rdata, rep(1'b1));
        @(negedge clk);
        chk("R8 held read unchanged after hand-off", rt_rdata, rep(1'b1));
        idle_side(1'b1);
        @(negedge clk);
        chk("R8 rdata zero once read ends", rt_rdata, '0);
        both_read_chk(15'd2, 1'b1, 1'b0, "R8 new read sees hand-off");
        tok_write(1'b1, 15'd2, 18'h00001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_claim_pass();
        test_tie();
        test_forbidden();
        test_addr_data_bits();
        test_snapshot();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule